// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA Engine

The engine walks a linked list of transmit descriptors held in memory. Each descriptor occupies four 32-bit words and carries an ownership bit. The engine sends one frame for every descriptor it owns and stops at the first descriptor that still belongs to the processor. Software fills in descriptors, hands them over by setting the ownership bit, and prods the engine with a kick strobe. The engine then fetches each descriptor over a word-wide memory port with a valid/ready handshake, and streams the frame bytes out on a byte-wide valid/ready interface. When a frame is done, it writes the descriptor back with ownership returned and completion status filled in, then follows the next-descriptor pointer.

A live current-descriptor pointer is always visible. While transmission is disabled and the engine is idle, the pointer follows the start-address input. When the engine halts on a processor-owned descriptor, the pointer stays on that descriptor. A later kick therefore resumes exactly where the walk stopped. Three sticky status flags record frame completion, per-descriptor interrupt requests and the halt, and they are cleared by write-one pulses. Two enables select which of the first two flags drive the interrupt line.

Top module: `txd_dma`

## Requirements
- R1: After reset the engine is idle, all three status flags and the interrupt are low, no memory request or stream byte is offered, and the current-descriptor pointer equals the start address.
- R2: A descriptor is read as four little-endian words at offsets +0 (control: bit 31 = 1 device-owned, bit 2 = interrupt request), +4 (buffer byte address), +8 (status/length, length in bits 15:0) and +12 (next descriptor). If bit 31 of the control word is 0, only that one word is read.
- R3: The frame is `length` bytes taken from consecutive byte addresses starting at the buffer address, at any alignment. Byte lane k of a memory word is bits 8k+7:8k. The final byte carries the last marker, and a zero length sends no bytes.
- R4: After a frame, the engine writes the control word back at +0 with bit 31 cleared and every other bit kept. It then writes the status word at +8 as the length in bits 15:0, bit 19 set, bit 16 equal to control bit 2, and all other bits zero.
- R5: After the write-back, the pointer moves to the next-descriptor address and the walk continues without another kick while transmission stays enabled.
- R6: On a processor-owned descriptor the engine sets the unavailable flag, goes idle, and leaves the pointer on that descriptor.
- R7: A kick after a halt refetches the descriptor the pointer is on, so no descriptor is skipped.
- R8: While transmission is disabled, a kick is ignored and an idle engine's pointer tracks the start address. Disabling mid-frame lets the current frame and its write-back finish, then the engine stops.
- R9: The complete flag sets on every frame, and the interrupt flag sets only on frames whose control bit 2 is 1. The three clear bits (2 = unavailable, 1 = complete, 0 = interrupt) clear their flags, and a set in the same cycle wins over a clear.
- R10: The interrupt line is high when the complete flag and its enable are both high, or when the interrupt flag and its enable are both high. The unavailable flag never raises it.
- R11: An offered memory request or stream byte holds its value until accepted, and a memory request and a stream byte are never offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Start address of the descriptor list |
| tx_en | input | 1 | Transmission enable |
| kick | input | 1 | Start/restart strobe |
| ie_done | input | 1 | Interrupt enable for the complete flag |
| ie_frame | input | 1 | Interrupt enable for the interrupt flag |
| sts_clr | input | 3 | Write-one clear pulses: 2 unavailable, 1 complete, 0 interrupt |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | AW | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte offered |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| cur_desc | output | AW | Current-descriptor pointer |
| busy | output | 1 | Engine is walking the list |
| st_done | output | 1 | Frame complete flag |
| st_frame | output | 1 | Per-descriptor interrupt flag |
| st_unavail | output | 1 | Descriptor unavailable flag |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the engine with a 12-bit address width. Its memory model of 1024 words then covers the whole address space, so every descriptor, buffer and write-back address the engine forms lands in modelled storage and can be compared. Random read latencies and random ready patterns on both interfaces reach every buffer alignment, zero-length frames, chains of one to four descriptors, and the resumption after a halt.

// File: rtl/txd_dma.sv
module txd_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          tx_en,
  input  logic          kick,
  input  logic          ie_done,
  input  logic          ie_frame,
  input  logic [2:0]    sts_clr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic [AW-1:0] cur_desc,
  output logic          busy,
  output logic          st_done,
  output logic          st_frame,
  output logic          st_unavail,
  output logic          irq
);

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DRSP, S_BREQ, S_BRSP, S_SEND, S_WB0, S_WB1
  } st_t;

  st_t           st;
  logic [1:0]    widx;
  logic [31:0]   flg;
  logic [31:0]   word;
  logic [AW-1:0] bptr;
  logic [AW-1:0] nxt;
  logic [15:0]   len;
  logic [15:0]   cnt;

  logic set_done, set_frame, set_un, rsp_take;

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_DREQ) || (st == S_BREQ) || (st == S_WB0) || (st == S_WB1);
  assign mem_req_write = (st == S_WB0) || (st == S_WB1);
  assign tx_valid      = (st == S_SEND);
  assign tx_data       = word[{bptr[1:0], 3'b000} +: 8];
  assign tx_last       = (cnt == len - 16'd1);

  always_comb begin
    case (st)
      S_BREQ:  mem_req_addr = {bptr[AW-1:2], 2'b00};
      S_WB0:   mem_req_addr = cur_desc;
      S_WB1:   mem_req_addr = cur_desc + AW'(8);
      default: mem_req_addr = cur_desc + AW'({widx, 2'b00});
    endcase
  end

  assign mem_req_wdata = (st == S_WB0) ? {1'b0, flg[30:0]}
                                       : {12'd0, 1'b1, 2'd0, flg[2], len};

  assign rsp_take  = (st == S_DRSP) && mem_rsp_valid;
  assign set_un    = rsp_take && (widx == 2'd0) && !mem_rsp_data[31];
  assign set_done  = (st == S_WB1) && mem_req_ready;
  assign set_frame = set_done && flg[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      widx <= 2'd0;
      flg  <= '0;
      word <= '0;
      bptr <= '0;
      nxt  <= '0;
      len  <= '0;
      cnt  <= '0;
      cur_desc <= ring_base;
    end else begin
      case (st)
        S_IDLE: begin
          if (!tx_en) cur_desc <= ring_base;
          if (tx_en && kick) begin
            widx <= 2'd0;
            st   <= S_DREQ;
          end
        end
        S_DREQ: if (mem_req_ready) st <= S_DRSP;
        S_DRSP: if (mem_rsp_valid) begin
          case (widx)
            2'd0: flg  <= mem_rsp_data;
            2'd1: bptr <= mem_rsp_data[AW-1:0];
            2'd2: len  <= mem_rsp_data[15:0];
            default: nxt <= mem_rsp_data[AW-1:0];
          endcase
          widx <= widx + 2'd1;
          cnt  <= '0;
          if (set_un)
            st <= S_IDLE;
          else if (widx != 2'd3)
            st <= S_DREQ;
          else if (len == 16'd0)
            st <= S_WB0;
          else
            st <= S_BREQ;
        end
        S_BREQ: if (mem_req_ready) st <= S_BRSP;
        S_BRSP: if (mem_rsp_valid) begin
          word <= mem_rsp_data;
          st   <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          cnt  <= cnt + 16'd1;
          bptr <= bptr + AW'(1);
          if (tx_last)
            st <= S_WB0;
          else if (bptr[1:0] == 2'b11)
            st <= S_BREQ;
        end
        S_WB0: if (mem_req_ready) st <= S_WB1;
        S_WB1: if (mem_req_ready) begin
          cur_desc <= nxt;
          widx     <= 2'd0;
          st       <= tx_en ? S_DREQ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done    <= 1'b0;
      st_frame   <= 1'b0;
      st_unavail <= 1'b0;
    end else begin
      st_done    <= set_done  | (st_done    & ~sts_clr[1]);
      st_frame   <= set_frame | (st_frame   & ~sts_clr[0]);
      st_unavail <= set_un    | (st_unavail & ~sts_clr[2]);
    end
  end

  assign irq = (st_done & ie_done) | (st_frame & ie_frame);

endmodule

// File: rtl/txd_dma_chk.sv
module txd_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ring_base,
  input logic          tx_en,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic [AW-1:0] cur_desc,
  input logic          busy,
  input logic          st_done,
  input logic          st_frame,
  input logic          st_unavail,
  input logic          irq
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_one_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_valid, tx_valid}));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !tx_valid);

  p_halt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_unavail) |-> !busy);

  p_follow_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !busy |=> cur_desc == $past(ring_base));

  p_frame_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_frame) |-> st_done);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_done && !st_frame |-> !irq);

endmodule

bind txd_dma txd_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .tx_en(tx_en),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .cur_desc(cur_desc), .busy(busy),
  .st_done(st_done), .st_frame(st_frame), .st_unavail(st_unavail), .irq(irq)
);

// File: tb/txd_dma_bench.sv
module txd_dma_bench;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic          tx_en = 1'b0, kick = 1'b0, ie_done = 1'b0, ie_frame = 1'b0;
  logic [2:0]    sts_clr = '0;
  logic          mem_req_valid, mem_req_write;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [31:0]   mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          tx_valid, tx_last;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;
  logic [AW-1:0] cur_desc;
  logic          busy, st_done, st_frame, st_unavail, irq;

  txd_dma #(.AW(AW)) u_txd_dma (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [7:0]  cap_b [0:4095];
  int          cap_n, lasts, rd_n;
  logic [AW-1:0] rd_last;
  logic [7:0]  exp_b [0:4095];
  int          exp_n, exp_frames;
  logic [31:0] e_flags [0:7];
  logic [15:0] e_len [0:7];
  int          nchk = 0, nfail = 0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_byte(input int a, input logic [7:0] v);
    mem[a >> 2][8*(a % 4) +: 8] = v;
  endtask

  initial begin : model
    bit          pend = 0;
    int          dly = 0;
    logic [AW-1:0] paddr = '0;
    forever begin
      @(negedge clk);
      if (pend && dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[paddr[11:2]];
        pend = 0;
      end else begin
        mem_rsp_valid = 1'b0;
        if (pend) dly--;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_write) mem[mem_req_addr[11:2]] = mem_req_wdata;
        else begin
          pend = 1; paddr = mem_req_addr; dly = $urandom % 3;
          rd_n++; rd_last = mem_req_addr;
        end
      end
      tx_ready = ($urandom % 3) != 0;
      if (rst_n && tx_valid && tx_ready) begin
        cap_b[cap_n] = tx_data;
        cap_n++;
        if (tx_last) lasts++;
      end
    end
  end

  task automatic kick_pulse();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    chk(!busy, "R5 walk ends (local watchdog)", busy, 0);
  endtask

  task automatic clear_all();
    sts_clr = 3'b111;
    @(negedge clk);
    sts_clr = 3'b000;
  endtask

  task automatic reload(input logic [AW-1:0] b);
    tx_en = 1'b0;
    ring_base = b;
    @(negedge clk);
    @(negedge clk);
    chk(cur_desc == b, "R8 pointer tracks start address", cur_desc, b);
    tx_en = 1'b1;
  endtask

  // Builds n device-owned descriptors at base followed by one processor-owned one.
  task automatic build_chain(input int base, input int n, input int maxl, output bit any_int);
    any_int = 0;
    exp_n = 0; exp_frames = 0;
    for (int k = 0; k < n; k++) begin
      int d = base + 16*k;
      int b = 'h400 + k*'h100 + ($urandom % 4);
      logic [15:0] l = 16'($urandom % (maxl + 1));
      logic [31:0] f = ($urandom | 32'h8000_0000);
      e_flags[k] = f; e_len[k] = l;
      if (f[2]) any_int = 1;
      mem[d/4]     = f;
      mem[d/4 + 1] = 32'(b);
      mem[d/4 + 2] = {$urandom % 65536, l} | 32'h0;
      mem[d/4 + 2][31:16] = 16'($urandom);
      mem[d/4 + 3] = 32'(d + 16);
      for (int j = 0; j < l; j++) begin
        logic [7:0] v = 8'($urandom);
        set_byte(b + j, v);
        exp_b[exp_n] = v;
        exp_n++;
      end
      if (l != 0) exp_frames++;
    end
    mem[(base + 16*n)/4] = $urandom & 32'h7fff_ffff;
  endtask

  task automatic verify_chain(input int base, input int n, input bit any_int);
    int bad = 0;
    chk(cap_n == exp_n, "R3 byte count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (cap_b[i] !== exp_b[i]) bad++;
    chk(bad == 0, "R3 byte values in lane order", bad, 0);
    chk(lasts == exp_frames, "R3 last markers", lasts, exp_frames);
    for (int k = 0; k < n; k++) begin
      int d = base + 16*k;
      logic [31:0] es = {12'd0, 1'b1, 2'd0, e_flags[k][2], e_len[k]};
      chk(mem[d/4] == (e_flags[k] & 32'h7fff_ffff), "R4 control write-back", mem[d/4], e_flags[k] & 32'h7fff_ffff);
      chk(mem[d/4 + 2] == es, "R4 status write-back", mem[d/4 + 2], es);
    end
    chk(cur_desc == AW'(base + 16*n), "R5 R6 pointer on halting descriptor", cur_desc, base + 16*n);
    chk(st_unavail == 1'b1, "R6 unavailable flag", st_unavail, 1);
    chk(st_done == (n > 0), "R9 complete flag", st_done, n > 0);
    chk(st_frame == any_int, "R9 interrupt flag follows control bit 2", st_frame, any_int);
  endtask

  task automatic run_chain(input int base, input int n, input int maxl);
    bit ai;
    build_chain(base, n, maxl, ai);
    clear_all();
    cap_n = 0; lasts = 0;
    kick_pulse();
    wait_idle();
    verify_chain(base, n, ai);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int base;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    cap_n = 0; lasts = 0; rd_n = 0;
    ring_base = 12'h100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 idle after reset", busy, 0);
    chk({st_done, st_frame, st_unavail, irq} == 4'b0, "R1 flags and irq low", {st_done, st_frame, st_unavail, irq}, 0);
    chk(!mem_req_valid && !tx_valid, "R1 no traffic", {mem_req_valid, tx_valid}, 0);
    chk(cur_desc == 12'h100, "R1 pointer equals start address", cur_desc, 12'h100);

    // Directed chain then random chains; one all-zero-length chain
    reload(12'h100);
    run_chain('h100, 3, 40);
    reload(12'h200);
    run_chain('h200, 2, 0);
    for (int r = 0; r < 8; r++) begin
      base = 16 * ($urandom % 40);
      reload(AW'(base));
      run_chain(base, 1 + ($urandom % 4), 60);
    end

    // R10 interrupt enables
    clear_all();
    chk(!st_done && !st_frame && !st_unavail, "R9 clear pulses", {st_done, st_frame, st_unavail}, 0);
    reload(12'h300);
    begin
      bit ai;
      build_chain('h300, 1, 10, ai);
      mem['h300/4][2] = 1'b1;
      e_flags[0][2] = 1'b1;
      clear_all(); cap_n = 0; lasts = 0;
      kick_pulse(); wait_idle();
      verify_chain('h300, 1, 1);
    end
    ie_done = 0; ie_frame = 0; @(negedge clk);
    chk(irq == 0, "R10 irq low with enables off (unavailable set)", irq, 0);
    ie_frame = 1; @(negedge clk);
    chk(irq == 1, "R10 irq from interrupt flag", irq, 1);
    sts_clr = 3'b001; @(negedge clk); sts_clr = 0;
    chk(irq == 0 && st_done, "R9 R10 selective clear", irq, 0);
    ie_done = 1; @(negedge clk);
    chk(irq == 1, "R10 irq from complete flag", irq, 1);
    ie_done = 0; ie_frame = 0;

    // R7 resume after halt on same descriptor (pointer now 0x310)
    run_chain('h310, 1, 30);
    chk(cur_desc == 12'h320, "R7 resumed at halted descriptor", cur_desc, 12'h320);

    // R2 processor-owned descriptor: one read at the pointer only
    clear_all();
    rd_n = 0; cap_n = 0;
    kick_pulse(); wait_idle();
    chk(rd_n == 1, "R2 single control-word read", rd_n, 1);
    chk(rd_last == 12'h320, "R2 read at pointer", rd_last, 12'h320);
    chk(st_unavail && cap_n == 0, "R6 halt without bytes", cap_n, 0);

    // R8 kick ignored while disabled
    tx_en = 0; rd_n = 0;
    kick_pulse();
    chk(!busy && rd_n == 0, "R8 kick ignored when disabled", rd_n, 0);

    // R8 disable mid-frame
    reload(12'h080);
    begin
      bit ai;
      build_chain('h080, 2, 0, ai);
      mem['h080/4 + 2][15:0] = 16'd20; e_len[0] = 20;
      mem['h090/4 + 2][15:0] = 16'd20;
      for (int j = 0; j < 20; j++) exp_b[j] = mem[('h400 + j) / 4][0 +: 8];
      clear_all(); cap_n = 0; lasts = 0;
      kick_pulse();
      for (int i = 0; i < 5000 && cap_n == 0; i++) @(negedge clk);
      tx_en = 0;
      wait_idle();
      chk(cap_n == 20 && lasts == 1, "R8 current frame finishes", cap_n, 20);
      chk(mem['h080/4][31] == 0, "R8 write-back of finished frame", mem['h080/4][31], 0);
      chk(mem['h090/4][31] == 1, "R8 next descriptor untouched", mem['h090/4][31], 1);
      chk(cur_desc == 12'h090 && !st_unavail, "R8 stops on next pointer", cur_desc, 12'h090);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule